// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one SMBus host request into the ordered list of byte-level bus operations that a lower I2C bit engine carries out. Software-visible values arrive as an 8-bit transaction code, an address byte (7-bit target in bits 7:1, direction in bit 0 with 1 meaning read), a command byte and two data bytes. A one-cycle `start` pulse latches them and the sequencer issues start, send-byte, receive-with-ACK, receive-with-NAK, repeated-start and stop requests one at a time, each held until the bit engine pulses `op_done`.

Supported transactions are quick, byte, byte-data, word-data, SMBus block (read and write) and I2C block read. Read results land in the data-0/data-1 result registers, and block payload bytes stream out with an index. Block-write payload is fetched through `blk_idx`/`blk_wdata`. A NAK from the device on any byte the host sends ends the transfer with a stop and a device-error flag. Bit timing, arbitration and packet error checking sit elsewhere.

The control is a single FSM with the states S_IDLE, S_START, S_ADDR1, S_CMD, S_TXD0, S_TXD1, S_TXCNT, S_TXBLK, S_RSTART, S_ADDR2, S_RXLEN, S_RXDAT and S_STOP. Every transition waits for `op_done`. S_IDLE goes to S_START on a supported `start` and stays put otherwise. S_START goes to S_ADDR1. S_ADDR1 goes to S_STOP on a NAK or for quick, to S_RXDAT for a byte read, and to S_CMD for everything else. S_CMD goes to S_STOP on a NAK or for a byte write, to S_RSTART for any read that has a command byte, to S_TXD0 for byte-data and word writes, and to S_TXCNT for a block write. S_TXD0 goes to S_TXD1 for a word write and to S_STOP otherwise. S_TXD1 goes to S_STOP. S_TXCNT goes to S_TXBLK, or to S_STOP on a NAK or a zero count. S_TXBLK repeats until the last byte or a NAK, then goes to S_STOP. S_RSTART goes to S_ADDR2. S_ADDR2 goes to S_STOP on a NAK, to S_RXLEN for an SMBus block read, and to S_RXDAT otherwise. S_RXLEN goes to S_RXDAT for a valid length and to S_STOP for a bad one. S_RXDAT repeats until the last byte, then goes to S_STOP. S_STOP returns to S_IDLE and pulses `done`.

Top module: `smbus_xact_seq`

## Requirements
- R1: Codes 0x00 quick, 0x04 byte, 0x08 byte-data, 0x0C word-data, 0x14 SMBus block and 0x18 I2C block read are accepted. Any other code, process call 0x10 included, issues no bus operation and produces `done` with `proto_err` one cycle after `start`.
- R2: `op_kind` uses 0 start, 1 repeated start, 2 send, 3 receive-with-ACK, 4 receive-with-NAK and 5 stop. `op_valid` is high only while busy, and `op_valid` and `op_kind` hold steady until the cycle that `op_done` is high.
- R3: A quick transaction is start, send of the address byte exactly as given, and stop.
- R4: A byte write is start, address, command byte, stop. A byte read is start, address (direction 1), one receive-with-NAK stored in data-0, stop.
- R5: Byte-data and word-data writes send start, address with direction 0, command, data-0, then data-1 for a word (low byte first), and stop.
- R6: Byte-data and word-data reads send start, address with bit 0 cleared, command, repeated start, address with bit 0 set, the data bytes and stop. A byte-data result goes to data-0, and a word result goes to data-0 (low) and data-1 (high).
- R7: Within each read, every received byte except the last is requested with ACK, and the last one with NAK.
- R8: A NAK reported on any send ends the transfer: the next operation is stop, and `done` comes with `dev_err` and leaves the result registers unchanged.
- R9: An SMBus block write sends start, address with direction 0, command, a count byte equal to data-0 limited to BLK_MAX, then that many bytes read from `blk_wdata` at `blk_idx` 0, 1, ..., then stop.
- R10: An SMBus block read receives the length byte first, with ACK, and stores it in data-0. For a length of 1..BLK_MAX, that many payload bytes follow on `rx_data`/`rx_idx`. A length of 0 or above BLK_MAX is followed at once by stop and `done` with `proto_err`.
- R11: An I2C block read (0x18) sends the address with bit 0 forced to 0, takes its command byte from data-1, then does a repeated start, an address with bit 0 set, and receives data-0 bytes, with 0 treated as 1 and values above BLK_MAX treated as BLK_MAX.
- R12: `done` is a one-cycle pulse seen with `busy` low. A `start` while busy is ignored, and the running transfer proceeds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction with the current register values |
| xact_code | input | 8 | Transaction code |
| addr_byte | input | 8 | Target address (7:1) and direction (0, 1 = read) |
| cmd_byte | input | 8 | Command byte |
| data0_in | input | 8 | Data-0 register: low byte or count |
| data1_in | input | 8 | Data-1 register: high byte or I2C read command |
| blk_wdata | input | 8 | Block-write payload byte at `blk_idx` |
| blk_idx | output | CNT_W | Index of the block-write byte wanted |
| op_valid | output | 1 | Byte operation request |
| op_kind | output | 3 | Operation code (see R2) |
| op_wdata | output | 8 | Byte to send |
| op_done | input | 1 | Bit engine finished the current operation |
| op_nak | input | 1 | Device NAKed the sent byte (with `op_done`) |
| op_rdata | input | 8 | Received byte (with `op_done`) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (one cycle) |
| dev_err | output | 1 | Device NAK ended the transfer (with `done`) |
| proto_err | output | 1 | Bad code or bad block length (with `done`) |
| data0_out | output | 8 | Data-0 result register |
| data1_out | output | 8 | Data-1 result register |
| rx_valid | output | 1 | Block payload byte received |
| rx_data | output | 8 | Block payload byte |
| rx_idx | output | CNT_W | Position of the payload byte |

## Verification
The bench models the bit engine with random latency, replays each transaction's full operation list and compares it with a list built from the requirements. The corner cases it targets are the following. A NAK injected on each send position has to end in a stop and must not touch the results; a design that ignored it would keep sending. Block lengths of 0, 1, BLK_MAX and above are used; a design with wrong bounds would run one byte too many or too few, or would accept a bogus length. An I2C block read has to pick data-1 and clear the direction bit, and a wrong design would send the command register or a read address first. The receive on the last byte must be a NAK, and the bench checks that no ACK lands there. A process-call code must produce no bus activity at all. A second `start` arriving mid-transfer must leave the sequence intact.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

    typedef enum logic [2:0] {
        OP_START    = 3'd0,
        OP_RSTART   = 3'd1,
        OP_SEND     = 3'd2,
        OP_RECV_ACK = 3'd3,
        OP_RECV_NAK = 3'd4,
        OP_STOP     = 3'd5
    } op_kind_e;

    typedef enum logic [2:0] {
        XK_QUICK,
        XK_BYTE,
        XK_BDATA,
        XK_WORD,
        XK_BLOCK,
        XK_I2CRD,
        XK_BAD
    } xact_kind_e;

    localparam logic [7:0] CODE_QUICK = 8'h00;
    localparam logic [7:0] CODE_BYTE  = 8'h04;
    localparam logic [7:0] CODE_BDATA = 8'h08;
    localparam logic [7:0] CODE_WORD  = 8'h0C;
    localparam logic [7:0] CODE_BLOCK = 8'h14;
    localparam logic [7:0] CODE_I2CRD = 8'h18;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_ADDR1,
        S_CMD,
        S_TXD0,
        S_TXD1,
        S_TXCNT,
        S_TXBLK,
        S_RSTART,
        S_ADDR2,
        S_RXLEN,
        S_RXDAT,
        S_STOP
    } seq_state_e;

endpackage

// File: rtl/smbus_code_decode.sv
module smbus_code_decode
    import smbus_seq_pkg::*;
(
    input  logic [7:0]  code,
    output xact_kind_e  kind
);
    always_comb begin
        case (code)
            CODE_QUICK: kind = XK_QUICK;
            CODE_BYTE:  kind = XK_BYTE;
            CODE_BDATA: kind = XK_BDATA;
            CODE_WORD:  kind = XK_WORD;
            CODE_BLOCK: kind = XK_BLOCK;
            CODE_I2CRD: kind = XK_I2CRD;
            default:    kind = XK_BAD;
        endcase
    end
endmodule

// File: rtl/smbus_len_calc.sv
module smbus_len_calc #(
    parameter int BLK_MAX = 32,
    parameter int CNT_W   = $clog2(BLK_MAX + 1)
) (
    input  logic [7:0]       count_reg,
    input  logic [7:0]       rx_len,
    output logic [CNT_W-1:0] wr_cnt,
    output logic [CNT_W-1:0] rd_cnt,
    output logic             len_ok
);
    localparam logic [7:0] MAX8 = 8'(BLK_MAX);

    // block write: clip count to the buffer size, zero allowed
    assign wr_cnt = CNT_W'((count_reg > MAX8) ? MAX8 : count_reg);
    // I2C block read: clip into 1..BLK_MAX
    assign rd_cnt = CNT_W'((count_reg == 8'd0) ? 8'd1 :
                           ((count_reg > MAX8) ? MAX8 : count_reg));
    // length byte returned by the device on an SMBus block read
    assign len_ok = (rx_len != 8'd0) && (rx_len <= MAX8);
endmodule

// File: rtl/smbus_seq_fsm.sv
module smbus_seq_fsm
    import smbus_seq_pkg::*;
#(
    parameter int BLK_MAX = 32,
    parameter int CNT_W   = $clog2(BLK_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  xact_kind_e       kind_in,
    input  logic [7:0]       addr_in,
    input  logic [7:0]       cmd_in,
    input  logic [7:0]       d0_in,
    input  logic [7:0]       d1_in,
    input  logic [7:0]       blk_wdata,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [CNT_W-1:0] rd_cnt,
    input  logic             len_ok,
    output logic [7:0]       d0_latched,
    output logic [CNT_W-1:0] blk_idx,
    output logic             op_valid,
    output logic [2:0]       op_kind,
    output logic [7:0]       op_wdata,
    input  logic             op_done,
    input  logic             op_nak,
    input  logic [7:0]       op_rdata,
    output logic             busy,
    output logic             done,
    output logic             dev_err,
    output logic             proto_err,
    output logic [7:0]       data0_out,
    output logic [7:0]       data1_out,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [CNT_W-1:0] rx_idx
);
    seq_state_e state_q, state_d;
    xact_kind_e kind_q;
    logic [7:0] addr_q, cmd_q, d0_q, d1_q;
    logic [CNT_W-1:0] cnt_q, idx_q;
    logic derr_pend, perr_pend;
    logic is_rd, sending, step;
    op_kind_e kind_e;

    assign is_rd      = addr_q[0];
    assign d0_latched = d0_q;
    assign blk_idx    = idx_q;
    assign busy       = (state_q != S_IDLE);
    assign step       = op_valid && op_done;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:
                if (start && kind_in != XK_BAD) state_d = S_START;
            S_START:
                if (op_done) state_d = S_ADDR1;
            S_ADDR1:
                if (op_done) begin
                    if (op_nak || kind_q == XK_QUICK)        state_d = S_STOP;
                    else if (kind_q == XK_BYTE && is_rd)     state_d = S_RXDAT;
                    else                                     state_d = S_CMD;
                end
            S_CMD:
                if (op_done) begin
                    if (op_nak || kind_q == XK_BYTE)         state_d = S_STOP;
                    else if (kind_q == XK_I2CRD || is_rd)    state_d = S_RSTART;
                    else if (kind_q == XK_BLOCK)             state_d = S_TXCNT;
                    else                                     state_d = S_TXD0;
                end
            S_TXD0:
                if (op_done) begin
                    if (!op_nak && kind_q == XK_WORD)        state_d = S_TXD1;
                    else                                     state_d = S_STOP;
                end
            S_TXD1:
                if (op_done) state_d = S_STOP;
            S_TXCNT:
                if (op_done) begin
                    if (op_nak || wr_cnt == '0)              state_d = S_STOP;
                    else                                     state_d = S_TXBLK;
                end
            S_TXBLK:
                if (op_done) begin
                    if (op_nak || cnt_q == CNT_W'(1))        state_d = S_STOP;
                end
            S_RSTART:
                if (op_done) state_d = S_ADDR2;
            S_ADDR2:
                if (op_done) begin
                    if (op_nak)                              state_d = S_STOP;
                    else if (kind_q == XK_BLOCK)             state_d = S_RXLEN;
                    else                                     state_d = S_RXDAT;
                end
            S_RXLEN:
                if (op_done) state_d = len_ok ? S_RXDAT : S_STOP;
            S_RXDAT:
                if (op_done && cnt_q == CNT_W'(1)) state_d = S_STOP;
            S_STOP:
                if (op_done) state_d = S_IDLE;
            default:
                state_d = S_IDLE;
        endcase
    end

    // ---------------- request outputs ----------------
    always_comb begin
        op_valid = 1'b1;
        kind_e   = OP_SEND;
        op_wdata = 8'h00;
        sending  = 1'b0;
        unique case (state_q)
            S_IDLE:   begin op_valid = 1'b0; kind_e = OP_START; end
            S_START:  kind_e = OP_START;
            S_RSTART: kind_e = OP_RSTART;
            S_STOP:   kind_e = OP_STOP;
            S_RXLEN:  kind_e = OP_RECV_ACK;
            S_RXDAT:  kind_e = (cnt_q == CNT_W'(1)) ? OP_RECV_NAK : OP_RECV_ACK;
            S_ADDR1: begin
                sending  = 1'b1;
                op_wdata = (kind_q == XK_QUICK || kind_q == XK_BYTE) ?
                           addr_q : {addr_q[7:1], 1'b0};
            end
            S_CMD: begin
                sending  = 1'b1;
                op_wdata = (kind_q == XK_I2CRD) ? d1_q : cmd_q;
            end
            S_TXD0:  begin sending = 1'b1; op_wdata = d0_q; end
            S_TXD1:  begin sending = 1'b1; op_wdata = d1_q; end
            S_TXCNT: begin sending = 1'b1; op_wdata = 8'(wr_cnt); end
            S_TXBLK: begin sending = 1'b1; op_wdata = blk_wdata; end
            S_ADDR2: begin sending = 1'b1; op_wdata = {addr_q[7:1], 1'b1}; end
            default: op_valid = 1'b0;
        endcase
    end
    assign op_kind = kind_e;

    // ---------------- datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= XK_QUICK;
            addr_q    <= '0;
            cmd_q     <= '0;
            d0_q      <= '0;
            d1_q      <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            derr_pend <= 1'b0;
            perr_pend <= 1'b0;
            done      <= 1'b0;
            dev_err   <= 1'b0;
            proto_err <= 1'b0;
            data0_out <= '0;
            data1_out <= '0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            rx_idx    <= '0;
        end else begin
            done      <= 1'b0;
            dev_err   <= 1'b0;
            proto_err <= 1'b0;
            rx_valid  <= 1'b0;

            if (state_q == S_IDLE && start) begin
                kind_q    <= kind_in;
                addr_q    <= addr_in;
                cmd_q     <= cmd_in;
                d0_q      <= d0_in;
                d1_q      <= d1_in;
                idx_q     <= '0;
                derr_pend <= 1'b0;
                perr_pend <= 1'b0;
                if (kind_in == XK_BAD) begin
                    done      <= 1'b1;
                    proto_err <= 1'b1;
                end
            end

            if (step && sending && op_nak) derr_pend <= 1'b1;

            if (step) begin
                unique case (state_q)
                    S_ADDR1: cnt_q <= CNT_W'(1);
                    S_ADDR2: begin
                        idx_q <= '0;
                        cnt_q <= (kind_q == XK_WORD)  ? CNT_W'(2) :
                                 (kind_q == XK_I2CRD) ? rd_cnt : CNT_W'(1);
                    end
                    S_TXCNT: begin
                        idx_q <= '0;
                        cnt_q <= wr_cnt;
                    end
                    S_TXBLK: begin
                        idx_q <= idx_q + CNT_W'(1);
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                    S_RXLEN: begin
                        data0_out <= op_rdata;
                        if (len_ok) cnt_q <= CNT_W'(op_rdata);
                        else        perr_pend <= 1'b1;
                    end
                    S_RXDAT: begin
                        if (kind_q == XK_BLOCK || kind_q == XK_I2CRD) begin
                            rx_valid <= 1'b1;
                            rx_data  <= op_rdata;
                            rx_idx   <= idx_q;
                        end else if (kind_q == XK_WORD && idx_q != '0) begin
                            data1_out <= op_rdata;
                        end else begin
                            data0_out <= op_rdata;
                        end
                        idx_q <= idx_q + CNT_W'(1);
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                    S_STOP: begin
                        done      <= 1'b1;
                        dev_err   <= derr_pend;
                        proto_err <= perr_pend;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- assertions ----------------
    AST_VALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> busy);                                                   // R2
    AST_KIND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_done) |=> (op_valid && $stable(op_kind)));           // R2
    AST_NAK_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_done && op_nak && op_kind == OP_SEND)
        |=> (op_valid && op_kind == OP_STOP));                                // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !op_valid));                                       // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                      // R12
    AST_DEVERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_err |-> done);                                                    // R8
    AST_RX_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_idx < CNT_W'(BLK_MAX)));                             // R11

endmodule

// File: rtl/smbus_xact_seq.sv
module smbus_xact_seq
    import smbus_seq_pkg::*;
#(
    parameter  int BLK_MAX = 32,
    localparam int CNT_W   = $clog2(BLK_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       xact_code,
    input  logic [7:0]       addr_byte,
    input  logic [7:0]       cmd_byte,
    input  logic [7:0]       data0_in,
    input  logic [7:0]       data1_in,
    input  logic [7:0]       blk_wdata,
    output logic [CNT_W-1:0] blk_idx,
    output logic             op_valid,
    output logic [2:0]       op_kind,
    output logic [7:0]       op_wdata,
    input  logic             op_done,
    input  logic             op_nak,
    input  logic [7:0]       op_rdata,
    output logic             busy,
    output logic             done,
    output logic             dev_err,
    output logic             proto_err,
    output logic [7:0]       data0_out,
    output logic [7:0]       data1_out,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [CNT_W-1:0] rx_idx
);
    xact_kind_e       kind;
    logic [7:0]       d0_latched;
    logic [CNT_W-1:0] wr_cnt, rd_cnt;
    logic             len_ok;

    smbus_code_decode u_dec (
        .code (xact_code),
        .kind (kind)
    );

    smbus_len_calc #(.BLK_MAX(BLK_MAX), .CNT_W(CNT_W)) u_len (
        .count_reg (d0_latched),
        .rx_len    (op_rdata),
        .wr_cnt    (wr_cnt),
        .rd_cnt    (rd_cnt),
        .len_ok    (len_ok)
    );

    smbus_seq_fsm #(.BLK_MAX(BLK_MAX), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .kind_in    (kind),
        .addr_in    (addr_byte),
        .cmd_in     (cmd_byte),
        .d0_in      (data0_in),
        .d1_in      (data1_in),
        .blk_wdata  (blk_wdata),
        .wr_cnt     (wr_cnt),
        .rd_cnt     (rd_cnt),
        .len_ok     (len_ok),
        .d0_latched (d0_latched),
        .blk_idx    (blk_idx),
        .op_valid   (op_valid),
        .op_kind    (op_kind),
        .op_wdata   (op_wdata),
        .op_done    (op_done),
        .op_nak     (op_nak),
        .op_rdata   (op_rdata),
        .busy       (busy),
        .done       (done),
        .dev_err    (dev_err),
        .proto_err  (proto_err),
        .data0_out  (data0_out),
        .data1_out  (data1_out),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_idx     (rx_idx)
    );
endmodule

// File: tb/smbus_xact_seq_tb.sv
module smbus_xact_seq_tb;
    localparam int BLK_MAX = 32;
    localparam int CNT_W   = $clog2(BLK_MAX + 1);
    localparam int K_START = 0, K_RS = 1, K_SEND = 2, K_RA = 3, K_RN = 4, K_STOP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] xact_code = 0, addr_byte = 0, cmd_byte = 0, data0_in = 0, data1_in = 0;
    logic [7:0] blk_wdata;
    logic [CNT_W-1:0] blk_idx, rx_idx;
    logic op_valid, busy, done, dev_err, proto_err, rx_valid;
    logic [2:0] op_kind;
    logic [7:0] op_wdata, data0_out, data1_out, rx_data;
    logic op_done = 1'b0, op_nak = 1'b0;
    logic [7:0] op_rdata = 8'h00;

    always #2 clk = ~clk;   // 250 MHz

    smbus_xact_seq #(.BLK_MAX(BLK_MAX)) u_dut (.*);

    logic [7:0] wr_mem [0:63];
    logic [7:0] rx_pat [0:63];
    int got_kind [0:63];
    logic [7:0] got_data [0:63];
    int exp_kind [0:63];
    logic [7:0] exp_data [0:63];
    logic [7:0] rx_got [0:63];
    int rx_got_idx [0:63];
    logic [7:0] rx_exp [0:63];
    int got_n, exp_n, rx_n, rx_en, eng_rx, nak_at;
    bit done_seen, derr_seen, perr_seen;
    int checks = 0, fails = 0;
    logic [7:0] m_d0 = 0, m_d1 = 0;

    assign blk_wdata = wr_mem[blk_idx];

    // bit engine model
    initial begin
        forever begin
            @(negedge clk);
            op_done = 1'b0;
            op_nak  = 1'b0;
            if (op_valid && rst_n) begin
                if (got_n < 64) begin
                    got_kind[got_n] = int'(op_kind);
                    got_data[got_n] = (op_kind == 3'd2) ? op_wdata : 8'h00;
                end
                repeat ($urandom % 3) @(negedge clk);
                op_done = 1'b1;
                op_nak  = (op_kind == 3'd2) && (got_n == nak_at);
                if (op_kind == 3'd3 || op_kind == 3'd4) begin
                    op_rdata = rx_pat[eng_rx];
                    eng_rx++;
                end
                got_n++;
            end
        end
    end

    // output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid && rx_n < 64) begin
                rx_got[rx_n] = rx_data;
                rx_got_idx[rx_n] = int'(rx_idx);
                rx_n++;
            end
            if (done) begin
                done_seen = 1'b1;
                derr_seen = dev_err;
                perr_seen = proto_err;
            end
        end
    end

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int k, input logic [7:0] d);
        exp_kind[exp_n] = k;
        exp_data[exp_n] = d;
        exp_n++;
    endtask

    task automatic run_xact(input logic [7:0] code, input logic [7:0] addr, input logic [7:0] cmd,
                            input logic [7:0] d0, input logic [7:0] d1, input int nak, input bit poke);
        logic [7:0] a0, a1, e_d0, e_d1;
        bit e_derr, e_perr;
        int n, len, w;
        string req;
        logic [7:0] pre_d0, pre_d1;
        a0 = {addr[7:1], 1'b0};
        a1 = {addr[7:1], 1'b1};
        pre_d0 = m_d0; pre_d1 = m_d1;
        e_d0 = m_d0; e_d1 = m_d1; e_derr = 0; e_perr = 0;
        exp_n = 0; rx_en = 0;
        case (code)
            8'h00: begin req = "R3"; push(K_START, 0); push(K_SEND, addr); push(K_STOP, 0); end
            8'h04: begin
                req = "R4";
                push(K_START, 0); push(K_SEND, addr);
                if (addr[0]) begin push(K_RN, 0); e_d0 = rx_pat[0]; end
                else push(K_SEND, cmd);
                push(K_STOP, 0);
            end
            8'h08, 8'h0C: begin
                req = addr[0] ? "R6" : "R5";
                push(K_START, 0); push(K_SEND, a0); push(K_SEND, cmd);
                if (addr[0]) begin
                    push(K_RS, 0); push(K_SEND, a1);
                    if (code == 8'h0C) begin
                        push(K_RA, 0); push(K_RN, 0); e_d0 = rx_pat[0]; e_d1 = rx_pat[1];
                    end else begin
                        push(K_RN, 0); e_d0 = rx_pat[0];
                    end
                end else begin
                    push(K_SEND, d0);
                    if (code == 8'h0C) push(K_SEND, d1);
                end
                push(K_STOP, 0);
            end
            8'h14: begin
                push(K_START, 0); push(K_SEND, a0); push(K_SEND, cmd);
                if (addr[0]) begin
                    req = "R10";
                    push(K_RS, 0); push(K_SEND, a1); push(K_RA, 0);
                    len = int'(rx_pat[0]);
                    e_d0 = rx_pat[0];
                    if (len == 0 || len > BLK_MAX) e_perr = 1;
                    else for (int i = 0; i < len; i++) begin
                        push((i == len - 1) ? K_RN : K_RA, 0);
                        rx_exp[rx_en++] = rx_pat[i + 1];
                    end
                end else begin
                    req = "R9";
                    w = (int'(d0) > BLK_MAX) ? BLK_MAX : int'(d0);
                    push(K_SEND, 8'(w));
                    for (int i = 0; i < w; i++) push(K_SEND, wr_mem[i]);
                end
                push(K_STOP, 0);
            end
            8'h18: begin
                req = "R11";
                n = (d0 == 0) ? 1 : ((int'(d0) > BLK_MAX) ? BLK_MAX : int'(d0));
                push(K_START, 0); push(K_SEND, a0); push(K_SEND, d1);
                push(K_RS, 0); push(K_SEND, a1);
                for (int i = 0; i < n; i++) begin
                    push((i == n - 1) ? K_RN : K_RA, 0);
                    rx_exp[rx_en++] = rx_pat[i];
                end
                push(K_STOP, 0);
            end
            default: begin req = "R1"; e_perr = 1; end
        endcase
        if (nak >= 0 && nak < exp_n && exp_kind[nak] == K_SEND) begin
            req = {req, "/R8"};
            exp_n = nak + 1;
            push(K_STOP, 0);
            e_derr = 1; e_perr = 0; e_d0 = pre_d0; e_d1 = pre_d1; rx_en = 0;
        end
        m_d0 = e_d0; m_d1 = e_d1;

        @(negedge clk);
        got_n = 0; rx_n = 0; eng_rx = 0; nak_at = nak;
        done_seen = 0; derr_seen = 0; perr_seen = 0;
        xact_code = code; addr_byte = addr; cmd_byte = cmd; data0_in = d0; data1_in = d1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            xact_code = 8'h00; addr_byte = ~addr; cmd_byte = ~cmd; data0_in = ~d0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            req = {req, "/R12"};
        end
        for (int t = 0; t < 3000 && !done_seen; t++) @(negedge clk);
        repeat (3) @(negedge clk);

        chk(req, "done seen", int'(done_seen), 1);
        chk(req, "op count", got_n, exp_n);
        checks++;
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (got_kind[i] != exp_kind[i] ||
                (exp_kind[i] == K_SEND && got_data[i] != exp_data[i])) begin
                fails++;
                $display("FAIL %s op %0d (R2/R7): actual=%0d/%0h expected=%0d/%0h",
                         req, i, got_kind[i], got_data[i], exp_kind[i], exp_data[i]);
                break;
            end
        end
        chk(req, "dev_err", int'(derr_seen), int'(e_derr));
        chk(req, "proto_err", int'(perr_seen), int'(e_perr));
        chk(req, "data0_out", int'(data0_out), int'(e_d0));
        chk(req, "data1_out", int'(data1_out), int'(e_d1));
        chk(req, "rx count", rx_n, rx_en);
        checks++;
        for (int i = 0; i < rx_en && i < rx_n; i++) begin
            if (rx_got[i] != rx_exp[i] || rx_got_idx[i] != i) begin
                fails++;
                $display("FAIL %s rx byte %0d: actual=%0h@%0d expected=%0h@%0d",
                         req, i, rx_got[i], rx_got_idx[i], rx_exp[i], i);
                break;
            end
        end
    endtask

    function automatic logic [7:0] pick_code(input int r);
        case (r % 7)
            0: return 8'h00;
            1: return 8'h04;
            2: return 8'h08;
            3: return 8'h0C;
            4: return 8'h14;
            5: return 8'h18;
            default: return 8'h10;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0123));
        got_n = 0; nak_at = -1; eng_rx = 0; rx_n = 0;
        for (int i = 0; i < 64; i++) begin
            wr_mem[i] = 8'($urandom);
            rx_pat[i] = 8'($urandom);
        end
        repeat (4) @(negedge clk);
        // reset state (R2, R12)
        chk("R2", "reset op_valid", int'(op_valid), 0);
        chk("R12", "reset busy", int'(busy), 0);
        chk("R12", "reset done", int'(done), 0);
        chk("R6", "reset data0_out", int'(data0_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        run_xact(8'h00, 8'hA4, 8'h00, 8'h00, 8'h00, -1, 0);          // R3 quick
        run_xact(8'h10, 8'h30, 8'h11, 8'h01, 8'h02, -1, 0);          // R1 process call
        run_xact(8'h0C, 8'h50, 8'h21, 8'h34, 8'h12, -1, 0);          // R5 word write
        run_xact(8'h0C, 8'h51, 8'h21, 8'h00, 8'h00, -1, 0);          // R6 word read
        run_xact(8'h08, 8'h50, 8'h21, 8'h77, 8'h00, 1, 0);           // R8 address NAK
        run_xact(8'h14, 8'h60, 8'h05, 8'd0, 8'h00, -1, 0);           // R9 zero count
        run_xact(8'h14, 8'h60, 8'h05, 8'd40, 8'h00, -1, 0);          // R9 clipped count
        run_xact(8'h14, 8'h60, 8'h05, 8'd6, 8'h00, -1, 1);           // R12 start while busy
        rx_pat[0] = 8'd0;
        run_xact(8'h14, 8'h61, 8'h05, 8'h00, 8'h00, -1, 0);          // R10 length 0
        rx_pat[0] = 8'd33;
        run_xact(8'h14, 8'h61, 8'h05, 8'h00, 8'h00, -1, 0);          // R10 length too big
        rx_pat[0] = 8'd32;
        run_xact(8'h14, 8'h61, 8'h05, 8'h00, 8'h00, -1, 0);          // R10 full length
        rx_pat[0] = 8'd1;
        run_xact(8'h14, 8'h61, 8'h05, 8'h00, 8'h00, -1, 0);          // R10 R7 single byte
        run_xact(8'h18, 8'h71, 8'h99, 8'd0, 8'h3C, -1, 0);           // R11 count 0 -> 1
        run_xact(8'h18, 8'h71, 8'h99, 8'd200, 8'h3C, -1, 0);         // R11 clipped count

        // constrained random
        for (int k = 0; k < 250; k++) begin
            logic [7:0] c, a, d0;
            int nk;
            c  = pick_code(int'($urandom));
            a  = 8'($urandom);
            d0 = (c == 8'h14 || c == 8'h18) ? 8'($urandom % 40) : 8'($urandom);
            nk = (($urandom % 4) == 0) ? int'($urandom % 6) : -1;
            for (int i = 0; i < 64; i++) begin
                wr_mem[i] = 8'($urandom);
                rx_pat[i] = 8'($urandom);
            end
            if (c == 8'h14) rx_pat[0] = 8'($urandom % 40);
            run_xact(c, a, 8'($urandom), d0, 8'($urandom), nk, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule